// File: doc/BRIEF.md
# DDR Command Bus Stretch and Park Controller

This block is the last stage between a memory controller's command scheduler and the DDR command/address pins. The scheduler offers one command and address at a time with a valid flag. The block accepts it when its ready output is high and places it on registered pin outputs. It then holds the command and address there for one, two or three clock cycles, depending on a 2-bit stretch mode. Ready stays low until the hold period ends, so the scheduler cannot issue into a stretch that is still running.

Between commands, a 1-bit parking policy sets what the bus carries. Under policy 0 the bus is driven with a deselect/NOP code while the channel is active. It is released to high impedance when every rank is in CKE-off or the memory is in self-refresh. Under policy 1 the bus is never released. It keeps re-driving the most recently issued command and address, or the NOP code with a zero address if nothing has been issued since reset. The configuration source is expected to come out of reset with 2-cycle stretching and policy 0.

Top module: `ddr_cmd_timing`

## Requirements
- R1: A command is accepted on a clock edge where `sched_valid` and `sched_ready` are both high. Its `sched_cmd` and `sched_addr` appear on `pin_cmd` and `pin_addr` directly after that edge.
- R2: `cfg_stretch` is sampled at acceptance. 2'b00 and the reserved 2'b01 give a 1-cycle hold, 2'b10 gives 2 cycles and 2'b11 gives 3 cycles.
- R3: An accepted command and its address stay unchanged on the pins for the whole hold length chosen in R2.
- R4: `sched_ready` is low during the cycles that follow an acceptance until the hold ends, which is hold length minus one cycles. It is high at all other times, whatever `sched_valid` does.
- R5: With `cfg_park` = 0 and no command being accepted or held, `pin_cmd` carries the NOP code (all ones) and `pin_addr` keeps its previous value.
- R6: With `cfg_park` = 1 and no command being accepted or held, the pins re-drive the last accepted command and address.
- R7: With `cfg_park` = 1, idle, and no command accepted since reset, `pin_cmd` is the NOP code and `pin_addr` is zero.
- R8: `pin_oe` updates one cycle after its inputs. It is 1 when `cfg_park` = 1. With `cfg_park` = 0 it is 0 exactly when `self_refresh` is high or every bit of `rank_cke_off` is high.
- R9: During reset, `pin_cmd` is NOP, `pin_addr` is zero, `pin_oe` is 0 and `sched_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_valid | input | 1 | Scheduler offers a command |
| sched_cmd | input | CMD_W | Command encoding; all ones is NOP/deselect |
| sched_addr | input | ADDR_W | Address and bank bits of the command |
| sched_ready | output | 1 | Block can accept a command this cycle |
| rank_cke_off | input | NRANK | Per-rank CKE-off status |
| self_refresh | input | 1 | Memory is in self-refresh or deeper |
| cfg_stretch | input | 2 | Hold-length mode |
| cfg_park | input | 1 | Idle policy: 0 release when powered down, 1 always drive |
| pin_cmd | output | CMD_W | Command pins |
| pin_addr | output | ADDR_W | Address pins |
| pin_oe | output | 1 | Output enable for command/address pins |

## Verification
Back-to-back valid commands in each stretch mode, including the reserved code, show whether the hold length and the ready gap match the mode, and whether a longer mode would let a command overwrite one still being held. Single commands followed by idle gaps separate the two parking policies. The gaps also show the difference between re-driving history and the NOP-with-zero state right after reset, which a second mid-run reset exercises again. A sweep over parking policy, self-refresh and all, some or no ranks in CKE-off checks the output enable, and long random runs mix mode changes and policy switches in the middle of idle stretches.

// File: rtl/ddr_cmdbus_pkg.sv
package ddr_cmdbus_pkg;

  typedef enum logic [1:0] {
    HOLD_ONE  = 2'b00,
    HOLD_RSVD = 2'b01,
    HOLD_TWO  = 2'b10,
    HOLD_THREE = 2'b11
  } hold_mode_e;

  localparam int unsigned MAX_HOLD = 3;
  localparam int unsigned REM_W    = $clog2(MAX_HOLD);

  // Cycles a command stays on the pins beyond its first cycle.
  function automatic logic [REM_W-1:0] extra_hold(input logic [1:0] mode);
    logic [REM_W-1:0] r;
    case (hold_mode_e'(mode))
      HOLD_TWO:   r = REM_W'(1);
      HOLD_THREE: r = REM_W'(2);
      default:    r = '0;
    endcase
    return r;
  endfunction

  // Whether the pins must be driven for the given policy and power state.
  function automatic logic bus_drive(input logic park, input logic all_off,
                                     input logic in_sr);
    return park | ~(all_off | in_sr);
  endfunction

endpackage

// File: rtl/cmdbus_stretch.sv
module cmdbus_stretch
  import ddr_cmdbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] mode,
  output logic       ready,
  output logic       accept,
  output logic       busy
);

  logic [REM_W-1:0] rem_q;

  assign busy   = (rem_q != '0);
  assign ready  = ~busy;
  assign accept = req_valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (accept) rem_q <= extra_hold(mode);
    else if (busy)   rem_q <= rem_q - REM_W'(1);
  end

  // R2: single-cycle modes never block the next slot
  a_r2_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !mode[1] |=> ready);
  // R2 R4: two-cycle hold blocks exactly one slot
  a_r2_double_slot: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode == 2'b10 |=> !ready ##1 ready);
  // R2 R4: three-cycle hold blocks exactly two slots
  a_r2_triple_slot: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode == 2'b11 |=> !ready ##1 !ready ##1 ready);

endmodule

// File: rtl/cmdbus_history.sv
module cmdbus_history #(
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic [CMD_W-1:0]  last_cmd,
  output logic [ADDR_W-1:0] last_addr,
  output logic              issued
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cmd  <= '1;
      last_addr <= '0;
      issued    <= 1'b0;
    end else if (accept) begin
      last_cmd  <= cmd;
      last_addr <= addr;
      issued    <= 1'b1;
    end
  end

  // R6: once set, the history flag stays set until reset
  a_r6_issued_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    issued |=> issued);

endmodule

// File: rtl/cmdbus_park.sv
module cmdbus_park
  import ddr_cmdbus_pkg::*;
#(
  parameter int unsigned NRANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             park,
  input  logic [NRANK-1:0] rank_cke_off,
  input  logic             self_refresh,
  output logic             oe
);

  logic [NRANK:0] off_chain;
  logic           all_off;

  assign off_chain[0] = 1'b1;
  for (genvar g = 0; g < NRANK; g++) begin : g_rank
    assign off_chain[g+1] = off_chain[g] & rank_cke_off[g];
  end
  assign all_off = off_chain[NRANK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe <= 1'b0;
    else        oe <= bus_drive(park, all_off, self_refresh);
  end

  // R8: always-drive policy keeps the pins enabled
  a_r8_park_drives: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> oe);
  // R8: powered-down channel under policy 0 releases the bus
  a_r8_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !park && (self_refresh || (&rank_cke_off)) |=> !oe);
  // R8: active channel under policy 0 drives the bus
  a_r8_active_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !park && !self_refresh && !(&rank_cke_off) |=> oe);

endmodule

// File: rtl/ddr_cmd_timing.sv
module ddr_cmd_timing
  import ddr_cmdbus_pkg::*;
#(
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NRANK  = 4,
  parameter logic [CMD_W-1:0] NOP_CODE = {CMD_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_valid,
  input  logic [CMD_W-1:0]  sched_cmd,
  input  logic [ADDR_W-1:0] sched_addr,
  output logic              sched_ready,
  input  logic [NRANK-1:0]  rank_cke_off,
  input  logic              self_refresh,
  input  logic [1:0]        cfg_stretch,
  input  logic              cfg_park,
  output logic [CMD_W-1:0]  pin_cmd,
  output logic [ADDR_W-1:0] pin_addr,
  output logic              pin_oe
);

  // Named internal events
  logic              ev_accept;
  logic              ev_busy;
  logic              ev_idle;
  logic              hist_valid;
  logic [CMD_W-1:0]  hist_cmd;
  logic [ADDR_W-1:0] hist_addr;
  logic [CMD_W-1:0]  nxt_cmd;
  logic [ADDR_W-1:0] nxt_addr;

  cmdbus_stretch u_stretch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (sched_valid),
    .mode      (cfg_stretch),
    .ready     (sched_ready),
    .accept    (ev_accept),
    .busy      (ev_busy)
  );

  cmdbus_history #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (ev_accept),
    .cmd       (sched_cmd),
    .addr      (sched_addr),
    .last_cmd  (hist_cmd),
    .last_addr (hist_addr),
    .issued    (hist_valid)
  );

  cmdbus_park #(.NRANK(NRANK)) u_park (
    .clk          (clk),
    .rst_n        (rst_n),
    .park         (cfg_park),
    .rank_cke_off (rank_cke_off),
    .self_refresh (self_refresh),
    .oe           (pin_oe)
  );

  assign ev_idle = ~ev_accept & ~ev_busy;

  always_comb begin
    nxt_cmd  = pin_cmd;
    nxt_addr = pin_addr;
    if (ev_accept) begin
      nxt_cmd  = sched_cmd;
      nxt_addr = sched_addr;
    end else if (ev_idle) begin
      if (cfg_park && hist_valid) begin
        nxt_cmd  = hist_cmd;
        nxt_addr = hist_addr;
      end else if (cfg_park) begin
        nxt_cmd  = NOP_CODE;
        nxt_addr = '0;
      end else begin
        nxt_cmd  = NOP_CODE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_cmd  <= NOP_CODE;
      pin_addr <= '0;
    end else begin
      pin_cmd  <= nxt_cmd;
      pin_addr <= nxt_addr;
    end
  end

  // R1: accepted command reaches the pins on the next cycle
  a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> pin_cmd == $past(sched_cmd) && pin_addr == $past(sched_addr));
  // R3: no change on the pins while a hold is running
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy |=> $stable(pin_cmd) && $stable(pin_addr));
  // R5: policy 0 idle slot carries NOP and keeps the address
  a_r5_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle && !cfg_park |=> pin_cmd == NOP_CODE && $stable(pin_addr));
  // R6: policy 1 idle slot re-drives history
  a_r6_redrive: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle && cfg_park && hist_valid |=> pin_cmd == $past(hist_cmd) && pin_addr == $past(hist_addr));
  // R7: nothing issued yet means NOP with zero address
  a_r7_fresh_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_valid |-> pin_cmd == NOP_CODE && pin_addr == '0);

endmodule

// File: tb/tb_ddr_cmd_timing.sv
`timescale 1ns/1ps
module tb_ddr_cmd_timing;

  localparam int CW = 4;
  localparam int AW = 20;
  localparam int NR = 4;
  localparam logic [CW-1:0] NOP = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sched_valid = 1'b0;
  logic [CW-1:0] sched_cmd = '0;
  logic [AW-1:0] sched_addr = '0;
  logic          sched_ready;
  logic [NR-1:0] rank_cke_off = '0;
  logic          self_refresh = 1'b0;
  logic [1:0]    cfg_stretch = 2'b10;
  logic          cfg_park = 1'b0;
  logic [CW-1:0] pin_cmd;
  logic [AW-1:0] pin_addr;
  logic          pin_oe;

  always #2.5 clk = ~clk;

  ddr_cmd_timing #(.CMD_W(CW), .ADDR_W(AW), .NRANK(NR)) dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference model state
  logic [CW-1:0] m_cmd, m_lcmd;
  logic [AW-1:0] m_addr, m_laddr;
  logic          m_oe, m_issued;
  int            m_rem;
  string         m_tag;

  function automatic int hold_len(input logic [1:0] s);
    if (s == 2'b11) return 3;
    if (s == 2'b10) return 2;
    return 1;
  endfunction

  function automatic logic exp_oe(input logic park, input logic sr,
                                  input logic [NR-1:0] cke);
    if (park) return 1'b1;
    return !(sr || (cke == '1));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cmd = NOP; m_addr = '0; m_oe = 1'b0; m_rem = 0;
    m_lcmd = NOP; m_laddr = '0; m_issued = 1'b0; m_tag = "R9";
  endtask

  task automatic model_step();
    bit acc;
    acc = sched_valid && (m_rem == 0);
    if (acc) begin
      m_cmd = sched_cmd; m_addr = sched_addr; m_rem = hold_len(cfg_stretch) - 1;
      m_lcmd = sched_cmd; m_laddr = sched_addr; m_issued = 1'b1; m_tag = "R1";
    end else if (m_rem != 0) begin
      m_rem--; m_tag = "R3";
    end else if (cfg_park && m_issued) begin
      m_cmd = m_lcmd; m_addr = m_laddr; m_tag = "R6";
    end else if (cfg_park) begin
      m_cmd = NOP; m_addr = '0; m_tag = "R7";
    end else begin
      m_cmd = NOP; m_tag = "R5";
    end
    m_oe = exp_oe(cfg_park, self_refresh, rank_cke_off);
  endtask

  task automatic compare_all();
    chk({m_tag, " cmd"}, 32'(pin_cmd), 32'(m_cmd));
    chk({m_tag, " addr"}, 32'(pin_addr), 32'(m_addr));
    chk("R8 oe", 32'(pin_oe), 32'(m_oe));
    chk("R4 ready", 32'(sched_ready), 32'(m_rem == 0));
  endtask

  // Inputs are set just after a falling edge; results are compared at the next falling edge.
  task automatic cyc(input logic v, input logic [CW-1:0] c, input logic [AW-1:0] a,
                     input logic [1:0] s, input logic p, input logic [NR-1:0] k,
                     input logic sr);
    sched_valid = v; sched_cmd = c; sched_addr = a; cfg_stretch = s;
    cfg_park = p; rank_cke_off = k; self_refresh = sr;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sched_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    // R9: reset state
    chk("R9 cmd", 32'(pin_cmd), 32'(NOP));
    chk("R9 addr", 32'(pin_addr), 32'h0);
    chk("R9 oe", 32'(pin_oe), 32'h0);
    chk("R9 ready", 32'(sched_ready), 32'h1);
    rst_n = 1'b1;
  endtask

  // Directed R2: count ready-low slots after one accepted command.
  task automatic probe_len(input logic [1:0] s, input logic [CW-1:0] c);
    int lows;
    lows = 0;
    cyc(1'b1, c, 20'h0ABCD, s, 1'b0, '0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      if (!sched_ready) lows++;
      chk("R3 held cmd", 32'(pin_cmd), (i < hold_len(s)) ? 32'(c) : 32'(NOP));
      cyc(1'b0, '0, '0, s, 1'b0, '0, 1'b0);
    end
    chk("R2 hold slots", 32'(lows), 32'(hold_len(s) - 1));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    // R7: policy 1 before any command, then R6 re-drive
    cyc(1'b0, '0, '0, 2'b00, 1'b1, '0, 1'b0);
    cyc(1'b0, '0, '0, 2'b00, 1'b1, '0, 1'b1);
    cyc(1'b1, 4'h3, 20'h12345, 2'b00, 1'b1, '0, 1'b0);
    repeat (3) cyc(1'b0, '0, '0, 2'b00, 1'b1, '1, 1'b0);
    chk("R6 redrive cmd", 32'(pin_cmd), 32'h3);
    chk("R6 redrive addr", 32'(pin_addr), 32'h12345);

    // R5: policy 0 idle NOP, address retained
    cyc(1'b0, '0, '0, 2'b00, 1'b0, '0, 1'b0);
    chk("R5 nop", 32'(pin_cmd), 32'(NOP));
    chk("R5 addr kept", 32'(pin_addr), 32'h12345);

    // R2: each mode including reserved code
    probe_len(2'b00, 4'h2);
    probe_len(2'b01, 4'h5);
    probe_len(2'b10, 4'h6);
    probe_len(2'b11, 4'h4);

    // R1 R3: back-to-back valid commands in each mode
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 7; i++)
        cyc(1'b1, CW'(i), AW'(m * 16 + i), 2'(m), 1'b0, '0, 1'b0);

    // R8: policy x self-refresh x rank patterns
    for (int p = 0; p < 2; p++)
      for (int sr = 0; sr < 2; sr++)
        for (int k = 0; k < 3; k++)
          cyc(1'b0, '0, '0, 2'b00, 1'(p), (k == 0) ? '0 : (k == 1) ? 4'b1111 : 4'b1011, 1'(sr));

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [NR-1:0] k;
      k = ($urandom % 4 == 0) ? '1 : NR'($urandom);
      cyc(1'($urandom % 3 != 0), CW'($urandom), AW'($urandom), 2'($urandom),
          1'($urandom % 2), k, 1'($urandom % 5 == 0));
      if (i == 1500) begin
        do_reset();
        // R7: history cleared by reset
        cyc(1'b0, '0, '0, 2'b00, 1'b1, '0, 1'b0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule